// File: doc/BRIEF.md
# Long-Word Bundle Issue and Lane Router

This block takes one long instruction word per cycle. The word is a bundle of four simple operation slots. A three-bit format code at the top of the word sets, with no other input, which functional lane each slot goes to. There are five lanes: two integer lanes, a floating-point lane, a load/store lane and a branch lane. The hardware checks no dependencies and reorders nothing. Every slot reads a 64-entry integer register file in parallel, and all register writes from one bundle commit on the same clock edge. The condition flags change only for integer operations that set their flag-request bit.

Loads go out on a simple memory request port. The bundle input stalls through a valid/ready handshake until the load data returns. The floating-point and branch lanes are not executed here. Their slot words, and for the branch lane the first source operand, are sent out to the units that own them.

Top module: `vliw_issue_unit`

## Requirements
- R1: After reset, bundle_ready is 1, flags are 000, every register holds 0, and mem_req, fp_issue_valid, br_issue_valid and bundle_err are 0.
- R2: bundle_data[127:125] is the format code and bit 124 is reserved. Slot k sits in bits [31k+30:31k]. Each slot has these fields: opcode [30:27], flag request [26], destination [25:20], source 1 [19:14], source 2 [13:8], immediate [7:0]. For slots 0..3 the formats map as follows: format 0 is INT0, INT1, LSU, BR; format 1 is INT0, INT1, FP, LSU; format 2 is LSU, INT0, INT1, BR; format 3 is INT0, LSU, FP, BR.
- R3: The integer lanes decode these opcodes. 1 is dest = src1 + src2. 2 is dest = src1 - src2. 3 is dest = src1 + sign-extended immediate. 4 is dest = src1 - sign-extended immediate. Opcode 0 and any other code change neither registers nor flags.
- R4: Every slot reads its sources as they were before the bundle. A write by one slot is not seen by another slot in the same bundle.
- R5: When two slots of one bundle write the same register, the higher-numbered slot wins.
- R6: flags = {N, Z, C} in bits [2:0]. N is the result sign, Z means the result is zero, C is the carry out of an add or the borrow (src1 < operand, unsigned) of a subtract. Only integer operations with the flag request bit set update the flags, and the highest such slot wins. The flags change in no other case.
- R7: The load/store lane decodes opcode 2 as a store and opcode 1 as a load. One cycle after a store is accepted: mem_req = 1, mem_we = 1, mem_addr = src1 + sign-extended immediate, mem_wdata = src2. A load shows mem_req = 1 and mem_we = 0 with the same address. bundle_ready then stays 0 until mem_rvalid. On that edge mem_rdata is written to the load's destination, and bundle_ready is 1 in the next cycle.
- R8: One cycle after acceptance, a nonzero opcode in the floating-point lane sets fp_issue_valid with fp_issue_op equal to the slot word. A nonzero opcode in the branch lane sets br_issue_valid with br_issue_op equal to the slot word and br_operand equal to that slot's source 1 register.
- R9: Format codes 4 to 7, or a set reserved bit 124, make a bundle illegal. An illegal bundle writes no register or flag and causes no memory, floating-point or branch issue. bundle_err is 1 for exactly the one cycle after it is accepted.
- R10: Register 0 is an ordinary register: it can be written and read back like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bundle_valid | input | 1 | Bundle offered |
| bundle_ready | output | 1 | Bundle can be accepted this cycle |
| bundle_data | input | 128 | Format code, reserved bit, four slots |
| mem_req | output | 1 | Memory access request, one cycle |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load return data |
| mem_rvalid | input | 1 | Load return strobe |
| fp_issue_valid | output | 1 | Floating-point lane issue |
| fp_issue_op | output | 31 | Floating-point slot word |
| br_issue_valid | output | 1 | Branch lane issue |
| br_issue_op | output | 31 | Branch slot word |
| br_operand | output | 32 | Branch source 1 value |
| flags | output | 3 | {N, Z, C} |
| bundle_err | output | 1 | Illegal bundle was accepted |

## Verification
The assertions assume that the memory side raises mem_rvalid only while a load is outstanding, as a single-cycle strobe, and never at the same moment a bundle is offered for the same edge. The bench keeps to this: it raises the strobe for exactly one cycle, only after it has seen the load request go out and bundle_ready drop. The bench drives bundle_valid only when bundle_ready is high. It reads registers back through store bundles, which change neither registers nor flags, so the values it reads are the state left by the bundle under test.

// File: rtl/vliw_issue_pkg.sv
package vliw_issue_pkg;
  localparam int XLEN     = 32;
  localparam int NREG     = 64;
  localparam int RAW      = $clog2(NREG);
  localparam int NSLOT    = 4;
  localparam int SIDX_W   = $clog2(NSLOT);
  localparam int OPC_W    = 4;
  localparam int IMM_W    = 8;
  localparam int SLOT_W   = OPC_W + 1 + 3 * RAW + IMM_W;
  localparam int FMT_W    = 3;
  localparam int BUNDLE_W = 128;
  localparam int NFMT     = 4;
  localparam int NLANE    = 5;
  localparam int FLAG_W   = 3;

  localparam logic [OPC_W-1:0] OP_ADD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_SUB  = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADDI = 4'd3;
  localparam logic [OPC_W-1:0] OP_SUBI = 4'd4;
  localparam logic [OPC_W-1:0] OP_LD   = 4'd1;
  localparam logic [OPC_W-1:0] OP_ST   = 4'd2;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic             setf;
    logic [RAW-1:0]   rd;
    logic [RAW-1:0]   rs1;
    logic [RAW-1:0]   rs2;
    logic [IMM_W-1:0] imm;
  } slot_t;

  typedef enum logic [2:0] {
    LN_INT0 = 3'd0,
    LN_INT1 = 3'd1,
    LN_FP   = 3'd2,
    LN_LSU  = 3'd3,
    LN_BR   = 3'd4,
    LN_NONE = 3'd7
  } lane_e;

  // Routing table: lane for a given slot under a given format code
  function automatic lane_e route_of(input logic [FMT_W-1:0] fmt, input int s);
    lane_e l;
    l = LN_NONE;
    case (fmt)
      3'd0: case (s) 0: l = LN_INT0; 1: l = LN_INT1; 2: l = LN_LSU; default: l = LN_BR;  endcase
      3'd1: case (s) 0: l = LN_INT0; 1: l = LN_INT1; 2: l = LN_FP;  default: l = LN_LSU; endcase
      3'd2: case (s) 0: l = LN_LSU;  1: l = LN_INT0; 2: l = LN_INT1; default: l = LN_BR; endcase
      3'd3: case (s) 0: l = LN_INT0; 1: l = LN_LSU;  2: l = LN_FP;  default: l = LN_BR;  endcase
      default: l = LN_NONE;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/vliw_fmt_decode.sv
module vliw_fmt_decode
  import vliw_issue_pkg::*;
(
  input  logic [FMT_W-1:0]              fmt,
  input  logic                          rsvd,
  output logic                          legal,
  output lane_e [NSLOT-1:0]             slot_lane,
  output logic [NLANE-1:0]              lane_used,
  output logic [NLANE-1:0][SIDX_W-1:0]  lane_slot
);
  always_comb begin
    legal = (int'(fmt) < NFMT) && !rsvd;
    for (int s = 0; s < NSLOT; s++) begin
      slot_lane[s] = legal ? route_of(fmt, s) : LN_NONE;
    end
    for (int l = 0; l < NLANE; l++) begin
      lane_used[l] = 1'b0;
      lane_slot[l] = '0;
      for (int s = 0; s < NSLOT; s++) begin
        if (slot_lane[s] == lane_e'(l)) begin
          lane_used[l] = 1'b1;
          lane_slot[l] = SIDX_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/vliw_int_lane.sv
module vliw_int_lane
  import vliw_issue_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              en,
  input  logic [OPC_W-1:0]  opc,
  input  logic              setf,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DW-1:0]     src_a,
  input  logic [DW-1:0]     src_b,
  output logic              wen,
  output logic [DW-1:0]     result,
  output logic              fset,
  output logic [FLAG_W-1:0] fval
);
  logic [DW-1:0] rhs;
  logic          do_sub;
  logic          known;
  logic [DW:0]   wide;

  always_comb begin
    rhs    = src_b;
    do_sub = 1'b0;
    known  = 1'b1;
    case (opc)
      OP_ADD:  ;
      OP_SUB:  do_sub = 1'b1;
      OP_ADDI: rhs = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
      OP_SUBI: begin
        rhs    = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
        do_sub = 1'b1;
      end
      default: known = 1'b0;
    endcase
    wide   = do_sub ? ({1'b0, src_a} - {1'b0, rhs}) : ({1'b0, src_a} + {1'b0, rhs});
    result = wide[DW-1:0];
    wen    = en && known;
    fset   = wen && setf;
    fval   = {result[DW-1], (result == '0), wide[DW]};
  end
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
  parameter int DW   = 32,
  parameter int NR   = 64,
  parameter int NRD  = 8,
  parameter int NWR  = 5,
  parameter int AW   = $clog2(NR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata,
  input  logic [NWR-1:0]           we,
  input  logic [NWR-1:0][AW-1:0]   waddr,
  input  logic [NWR-1:0][DW-1:0]   wdata
);
  logic [DW-1:0] regs_q [NR];
  logic [DW-1:0] regs_d [NR];

  // Port order is write priority: higher index lands last
  always_comb begin
    regs_d = regs_q;
    for (int w = 0; w < NWR; w++) begin
      if (we[w]) regs_d[waddr[w]] = wdata[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) regs_q[i] <= '0;
    end else if (|we) begin
      regs_q <= regs_d;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = regs_q[raddr[r]];
  end

  // R7
  ld_port_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we[0] |-> !(|we[NWR-1:1]));
endmodule

// File: rtl/vliw_issue_unit.sv
module vliw_issue_unit
  import vliw_issue_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bundle_valid,
  output logic                bundle_ready,
  input  logic [BUNDLE_W-1:0] bundle_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [DW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  input  logic                mem_rvalid,
  output logic                fp_issue_valid,
  output logic [SLOT_W-1:0]   fp_issue_op,
  output logic                br_issue_valid,
  output logic [SLOT_W-1:0]   br_issue_op,
  output logic [DW-1:0]       br_operand,
  output logic [FLAG_W-1:0]   flags,
  output logic                bundle_err
);
  localparam int NRD = 2 * NSLOT;
  localparam int NWR = NSLOT + 1;
  localparam int NINT = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  slot_t [NSLOT-1:0] slots;
  logic              accept;
  logic              legal;
  lane_e [NSLOT-1:0] slot_lane;
  logic [NLANE-1:0]  lane_used;
  logic [NLANE-1:0][SIDX_W-1:0] lane_slot;
  logic [NLANE-1:0]  lane_act;
  slot_t [NLANE-1:0] lane_op;

  logic              ld_pend_q, ld_pend_d;
  logic [RAW-1:0]    ld_rd_q, ld_rd_d;

  assign slots        = bundle_data[NSLOT*SLOT_W-1:0];
  assign bundle_ready = !ld_pend_q;
  assign accept       = bundle_valid && bundle_ready;

  vliw_fmt_decode u_dec (
    .fmt       (bundle_data[BUNDLE_W-1 -: FMT_W]),
    .rsvd      (bundle_data[NSLOT*SLOT_W]),
    .legal     (legal),
    .slot_lane (slot_lane),
    .lane_used (lane_used),
    .lane_slot (lane_slot)
  );

  // register file: two reads per slot, one load port plus one write per slot
  logic [NRD-1:0][RAW-1:0] rf_raddr;
  logic [NRD-1:0][DW-1:0]  rf_rdata;
  logic [NWR-1:0]          rf_we;
  logic [NWR-1:0][RAW-1:0] rf_waddr;
  logic [NWR-1:0][DW-1:0]  rf_wdata;

  for (genvar s = 0; s < NSLOT; s++) begin : g_rsel
    assign rf_raddr[2*s]   = slots[s].rs1;
    assign rf_raddr[2*s+1] = slots[s].rs2;
  end

  vliw_regfile #(.DW(DW), .NR(NREG), .NRD(NRD), .NWR(NWR)) u_rf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .raddr (rf_raddr),
    .rdata (rf_rdata),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata)
  );

  // slot-to-lane steering
  always_comb begin
    for (int l = 0; l < NLANE; l++) begin
      lane_op[l]  = slots[lane_slot[l]];
      lane_act[l] = accept && lane_used[l];
    end
  end

  logic [NINT-1:0]             int_wen, int_fset;
  logic [NINT-1:0][DW-1:0]     int_res;
  logic [NINT-1:0][FLAG_W-1:0] int_fval;

  for (genvar i = 0; i < NINT; i++) begin : g_int
    vliw_int_lane #(.DW(DW)) u_int (
      .en     (lane_act[i]),
      .opc    (lane_op[i].opc),
      .setf   (lane_op[i].setf),
      .imm    (lane_op[i].imm),
      .src_a  (rf_rdata[2*lane_slot[i]]),
      .src_b  (rf_rdata[2*lane_slot[i]+1]),
      .wen    (int_wen[i]),
      .result (int_res[i]),
      .fset   (int_fset[i]),
      .fval   (int_fval[i])
    );
  end

  // write-back and flag selection, slot order gives priority
  logic [FLAG_W-1:0] flags_d;
  always_comb begin
    rf_we[0]    = ld_pend_q && mem_rvalid;
    rf_waddr[0] = ld_rd_q;
    rf_wdata[0] = mem_rdata;
    flags_d     = flags;
    for (int s = 0; s < NSLOT; s++) begin
      rf_we[s+1]    = 1'b0;
      rf_waddr[s+1] = slots[s].rd;
      rf_wdata[s+1] = '0;
      for (int i = 0; i < NINT; i++) begin
        if (slot_lane[s] == lane_e'(i)) begin
          rf_we[s+1]    = int_wen[i];
          rf_wdata[s+1] = int_res[i];
          if (int_fset[i]) flags_d = int_fval[i];
        end
      end
    end
  end

  // load/store lane
  logic [DW-1:0] lsu_a, lsu_b, lsu_addr;
  logic          is_ld, is_st;
  assign lsu_a    = rf_rdata[2*lane_slot[LN_LSU]];
  assign lsu_b    = rf_rdata[2*lane_slot[LN_LSU]+1];
  assign lsu_addr = lsu_a + {{(DW-IMM_W){lane_op[LN_LSU].imm[IMM_W-1]}}, lane_op[LN_LSU].imm};
  assign is_ld    = lane_act[LN_LSU] && (lane_op[LN_LSU].opc == OP_LD);
  assign is_st    = lane_act[LN_LSU] && (lane_op[LN_LSU].opc == OP_ST);

  logic fp_go, br_go;
  assign fp_go = lane_act[LN_FP] && (lane_op[LN_FP].opc != '0);
  assign br_go = lane_act[LN_BR] && (lane_op[LN_BR].opc != '0);

  always_comb begin
    ld_pend_d = ld_pend_q;
    ld_rd_d   = ld_rd_q;
    if (is_ld) begin
      ld_pend_d = 1'b1;
      ld_rd_d   = lane_op[LN_LSU].rd;
    end else if (ld_pend_q && mem_rvalid) begin
      ld_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ld_pend_q      <= 1'b0;
      ld_rd_q        <= '0;
      flags          <= '0;
      mem_req        <= 1'b0;
      mem_we         <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
      fp_issue_valid <= 1'b0;
      fp_issue_op    <= '0;
      br_issue_valid <= 1'b0;
      br_issue_op    <= '0;
      br_operand     <= '0;
      bundle_err     <= 1'b0;
    end else begin
      ld_pend_q      <= ld_pend_d;
      ld_rd_q        <= ld_rd_d;
      flags          <= flags_d;
      mem_req        <= is_ld || is_st;
      mem_we         <= is_st;
      fp_issue_valid <= fp_go;
      br_issue_valid <= br_go;
      bundle_err     <= accept && !legal;
      if (is_ld || is_st) mem_addr  <= lsu_addr;
      if (is_st)          mem_wdata <= lsu_b;
      if (fp_go)          fp_issue_op <= lane_op[LN_FP];
      if (br_go) begin
        br_issue_op <= lane_op[LN_BR];
        br_operand  <= rf_rdata[2*lane_slot[LN_BR]];
      end
    end
  end

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bundle_err |-> !mem_req && !fp_issue_valid && !br_issue_valid);

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bundle_valid && bundle_ready) |=> $stable(flags));

  // R7
  ld_stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_we) |-> !bundle_ready);

  // R7
  req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req |-> $past(bundle_valid && bundle_ready));
endmodule

// File: tb/vliw_issue_unit_bench.sv
`timescale 1ns/1ps
module vliw_issue_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bundle_valid;
  logic         bundle_ready;
  logic [127:0] bundle_data;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata;
  logic         mem_rvalid;
  logic         fp_issue_valid, br_issue_valid;
  logic [30:0]  fp_issue_op, br_issue_op;
  logic [31:0]  br_operand;
  logic [2:0]   flags;
  logic         bundle_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vliw_issue_unit u_vliw_issue_unit (
    .clk(clk), .rst_n(rst_n), .bundle_valid(bundle_valid), .bundle_ready(bundle_ready),
    .bundle_data(bundle_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .fp_issue_valid(fp_issue_valid), .fp_issue_op(fp_issue_op),
    .br_issue_valid(br_issue_valid), .br_issue_op(br_issue_op), .br_operand(br_operand),
    .flags(flags), .bundle_err(bundle_err)
  );

  function automatic logic [30:0] op(input logic [3:0] opc, input logic sf,
      input logic [5:0] rd, input logic [5:0] a, input logic [5:0] b, input logic [7:0] imm);
    return {opc, sf, rd, a, b, imm};
  endfunction

  function automatic logic [127:0] bun(input logic [2:0] fmt, input logic [30:0] s3,
      input logic [30:0] s2, input logic [30:0] s1, input logic [30:0] s0);
    return {fmt, 1'b0, s3, s2, s1, s0};
  endfunction

  typedef struct packed {
    logic [127:0] b;
    logic [5:0]   r;
    logic [31:0]  v;
    logic [2:0]   f;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{bun(3'd0, '0, '0, '0, op(4'd3, 1'b0, 6'd1, 6'd0, 6'd0, 8'd5)),    6'd1, 32'd5, 3'b000, 4'd3},  // R3 addi
    '{bun(3'd0, '0, '0, '0, op(4'd3, 1'b1, 6'd2, 6'd1, 6'd0, 8'hFD)),   6'd2, 32'd2, 3'b001, 4'd6},  // R6 carry
    '{bun(3'd0, '0, '0, op(4'd2, 1'b1, 6'd3, 6'd2, 6'd1, 8'd0), '0),    6'd3, 32'hFFFFFFFD, 3'b101, 4'd6}, // R6 borrow
    '{bun(3'd2, '0, '0, op(4'd1, 1'b1, 6'd4, 6'd1, 6'd2, 8'd0), '0),    6'd4, 32'd7, 3'b000, 4'd2},  // R2 fmt2
    '{bun(3'd2, '0, op(4'd2, 1'b1, 6'd5, 6'd1, 6'd1, 8'd0),
                    op(4'd1, 1'b1, 6'd6, 6'd1, 6'd1, 8'd0), '0),         6'd5, 32'd0, 3'b010, 4'd6},  // R6 high slot
    '{bun(3'd0, '0, '0, '0, '0),                                          6'd6, 32'd10, 3'b010, 4'd3}, // R3 nop
    '{bun(3'd1, '0, '0, op(4'd1, 1'b0, 6'd7, 6'd4, 6'd4, 8'd0),
                        op(4'd1, 1'b0, 6'd7, 6'd1, 6'd2, 8'd0)),         6'd7, 32'd14, 3'b010, 4'd5}, // R5
    '{bun(3'd3, '0, '0, '0, op(4'd4, 1'b1, 6'd0, 6'd1, 6'd0, 8'd1)),    6'd0, 32'd4, 3'b000, 4'd10}, // R10
    '{bun(3'd0, '0, '0, op(4'd3, 1'b0, 6'd2, 6'd1, 6'd0, 8'd0),
                        op(4'd3, 1'b0, 6'd1, 6'd2, 6'd0, 8'd0)),         6'd2, 32'd5, 3'b000, 4'd4},  // R4
    '{bun(3'd0, '0, '0, '0, '0),                                          6'd1, 32'd2, 3'b000, 4'd4},  // R4
    '{bun(3'd0, '0, '0, '0, op(4'd9, 1'b1, 6'd1, 6'd0, 6'd0, 8'h33)),   6'd1, 32'd2, 3'b000, 4'd3}   // R3 unknown
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] b);
    @(negedge clk);
    while (!bundle_ready) @(negedge clk);
    bundle_valid = 1'b1;
    bundle_data  = b;
    @(negedge clk);
    bundle_valid = 1'b0;
    bundle_data  = '0;
  endtask

  // read a register through a store: data = rf[r]
  task automatic peek(input logic [5:0] r, input logic [31:0] exp, input string tag);
    send(bun(3'd0, '0, op(4'd2, 1'b0, 6'd0, r, r, 8'd0), '0, '0));
    chk({tag, " store req"}, {31'd0, mem_req}, 32'd1);
    chk({tag, " reg value"}, mem_wdata, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bundle_valid = 1'b0; bundle_data = '0;
    mem_rdata = '0; mem_rvalid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 ready", {31'd0, bundle_ready}, 32'd1);
    chk("R1 flags", {29'd0, flags}, 32'd0);
    chk("R1 idle outputs", {28'd0, mem_req, fp_issue_valid, br_issue_valid, bundle_err}, 32'd0);
    peek(6'd63, 32'd0, "R1 r63");
    peek(6'd0, 32'd0, "R1 r0");

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].b);
      checks++;
      if (flags !== VECS[i].f) begin
        failures++;
        $display("FAIL R%0d vec %0d flags actual=%b expected=%b", VECS[i].req, i, flags, VECS[i].f);
      end
      send(bun(3'd0, '0, op(4'd2, 1'b0, 6'd0, VECS[i].r, VECS[i].r, 8'd0), '0, '0));
      checks++;
      if (mem_wdata !== VECS[i].v) begin
        failures++;
        $display("FAIL R%0d vec %0d reg actual=%h expected=%h", VECS[i].req, i, mem_wdata, VECS[i].v);
      end
    end

    // R7 store: addr = r4(7) + (-2), data = r6(10)
    send(bun(3'd0, '0, op(4'd2, 1'b0, 6'd0, 6'd4, 6'd6, 8'hFE), '0, '0));
    chk("R7 st req", {30'd0, mem_req, mem_we}, 32'd3);
    chk("R7 st addr", mem_addr, 32'd5);
    chk("R7 st data", mem_wdata, 32'd10);
    @(negedge clk);
    chk("R7 st pulse", {31'd0, mem_req}, 32'd0);

    // R7 load with a parallel integer op: addr = r1(2)+3
    send(bun(3'd0, '0, op(4'd1, 1'b0, 6'd9, 6'd1, 6'd0, 8'd3), '0,
             op(4'd3, 1'b0, 6'd10, 6'd0, 6'd0, 8'd1)));
    chk("R7 ld req", {30'd0, mem_req, mem_we}, 32'd2);
    chk("R7 ld addr", mem_addr, 32'd5);
    chk("R7 ld stall", {31'd0, bundle_ready}, 32'd0);
    @(negedge clk);
    chk("R7 ld still stalled", {31'd0, bundle_ready}, 32'd0);
    mem_rvalid = 1'b1; mem_rdata = 32'hCAFE1234;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    chk("R7 ready after return", {31'd0, bundle_ready}, 32'd1);
    peek(6'd9, 32'hCAFE1234, "R7 load dest");
    peek(6'd10, 32'd5, "R7 parallel int");

    // R8 floating-point lane, format 1 slot 2
    send(bun(3'd1, '0, op(4'd5, 1'b0, 6'd3, 6'd4, 6'd5, 8'h21), '0, '0));
    chk("R8 fp valid", {31'd0, fp_issue_valid}, 32'd1);
    chk("R8 fp op", {1'b0, fp_issue_op}, {1'b0, op(4'd5, 1'b0, 6'd3, 6'd4, 6'd5, 8'h21)});
    // R8 branch lane, format 0 slot 3, source r4 = 7
    send(bun(3'd0, op(4'd1, 1'b0, 6'd0, 6'd4, 6'd0, 8'h10), '0, '0, '0));
    chk("R8 br valid", {30'd0, br_issue_valid, fp_issue_valid}, 32'd2);
    chk("R8 br op", {1'b0, br_issue_op}, {1'b0, op(4'd1, 1'b0, 6'd0, 6'd4, 6'd0, 8'h10)});
    chk("R8 br operand", br_operand, 32'd7);

    // R9 illegal format 5: nothing may happen
    send(bun(3'd5, op(4'd1, 1'b0, 6'd0, 6'd4, 6'd0, 8'd0), op(4'd2, 1'b0, 6'd0, 6'd1, 6'd1, 8'd0),
             op(4'd1, 1'b1, 6'd1, 6'd4, 6'd4, 8'd0), op(4'd3, 1'b1, 6'd1, 6'd0, 6'd0, 8'd99)));
    chk("R9 err", {31'd0, bundle_err}, 32'd1);
    chk("R9 quiet", {29'd0, mem_req, fp_issue_valid, br_issue_valid}, 32'd0);
    chk("R9 flags kept", {29'd0, flags}, 32'd0);
    peek(6'd1, 32'd2, "R9 r1 kept");
    chk("R9 err one cycle", {31'd0, bundle_err}, 32'd0);
    // R9 reserved bit set with a legal format code
    send(bun(3'd0, '0, '0, '0, op(4'd3, 1'b0, 6'd1, 6'd0, 6'd0, 8'd40)) | (128'd1 << 124));
    chk("R9 rsvd err", {31'd0, bundle_err}, 32'd1);
    peek(6'd1, 32'd2, "R9 rsvd r1 kept");

    finish_run();
  end
endmodule